// File: doc/BRIEF.md
# External Bus Controller with Read-to-Write Turnaround Gap

This block runs single read and write cycles on an external 16-bit memory and I/O bus, on behalf of a simple internal requester. A request is taken while the controller is idle. A read takes three bus states (T1, T2, T3). A write takes two bus states (T1, T2). The controller drives the address bus, the data bus pad signals and active-low strobes. It returns the read data together with a one-clock done pulse.

Some slow external devices keep driving the data bus for a while after their read strobe is released. To keep such a device from colliding with the write data that comes next, the controller can add one idle state at the start of a write. It does this only when the last completed external cycle was a read and the gap enable input is 1 when the write request is taken.

During the idle state the new write address is already on the address bus. The data bus is not driven, and every strobe and select stays high. The data bus is split into an output value, an output enable and an input value, so that the pad ring outside the block can build the tri-state pad.

Top module: `ext_bus_gap_ctrl`

## Requirements
- R1: A read (`rnw`=1) holds `as_n`, `rd_n` and its select low for exactly three states, T1 to T3. `done` rises in the clock after T3. `rdata` then shows the `bus_din` value sampled at the end of T3. The write strobes stay high throughout.
- R2: A write (`rnw`=0) lasts two states, T1 and T2. In both states `as_n` and the select are low. `hwr_n` is low when `lanes[1]` is 1 (D15..D8), and `lwr_n` is low when `lanes[0]` is 1 (D7..D0). `bus_dout` carries the write data.
- R3: A write taken while `gap_en`=1, when the last completed external cycle was a read, gets exactly one idle state before its T1. Its total length from acceptance to `done` therefore grows by one clock.
- R4: No idle state is added when `gap_en`=0, when the previous completed cycle was a write, when no cycle has completed since reset, or to any read.
- R5: In the idle state, `bus_addr` already shows the write address and `bus_oe` is 0. `as_n`, `ios_n`, `cs_n`, `rd_n`, `hwr_n` and `lwr_n` are all 1.
- R6: `bus_oe` is 1 only in T1 and T2 of a write. It is 0 in the idle state, in read states and while the controller is idle.
- R7: An address whose top 8 bits are all ones selects the I/O space: `ios_n` goes low and `cs_n` stays high. Any other address does the reverse. At most one of the two is low at any time.
- R8: `done` is a single-clock pulse. A request presented in the clock where `done` is high is taken at once, so back-to-back cycles have no dead state between them.
- R9: After reset, all strobes and selects are high, `bus_oe` and `done` are 0, and no read is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_en | input | 1 | Enables the read-to-write idle state |
| req | input | 1 | Cycle request, taken while idle |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Cycle address |
| wdata | input | 16 | Write data |
| lanes | input | 2 | Byte lanes written: bit 1 = D15..D8, bit 0 = D7..D0 |
| bus_addr | output | AW | External address bus |
| bus_dout | output | 16 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus input value |
| as_n | output | 1 | Address strobe, active low |
| ios_n | output | 1 | I/O space select, active low |
| cs_n | output | 1 | Memory space select, active low |
| rd_n | output | 1 | Read strobe, active low |
| hwr_n | output | 1 | High byte write strobe, active low |
| lwr_n | output | 1 | Low byte write strobe, active low |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | One-clock cycle completion pulse |

## Verification
The completion of one cycle and the acceptance of the next request happen in the same clock, whenever the requester raises `req` in the cycle where `done` is high. In that case the flag recording "last cycle was a read" is updated in the very clock in which the next request checks it for gap insertion.

The bench provokes this by issuing many requests with zero spacing, both in a directed read-then-write sequence and in random traffic. It judges the result from the measured acceptance-to-done length of each cycle and from the pin levels in the first state after acceptance. Both are compared with a bench model of the previous cycle's direction.

// File: rtl/ext_bus_gap_ctrl.sv
module ext_bus_gap_ctrl #(
  parameter int AW       = 24,
  parameter int IO_TAG_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gap_en,
  input  logic          req,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic [1:0]    lanes,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_dout,
  output logic          bus_oe,
  input  logic [15:0]   bus_din,
  output logic          as_n,
  output logic          ios_n,
  output logic          cs_n,
  output logic          rd_n,
  output logic          hwr_n,
  output logic          lwr_n,
  output logic [15:0]   rdata,
  output logic          done
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_GAP  = 3'd1;
  localparam logic [2:0] S_T1   = 3'd2;
  localparam logic [2:0] S_T2   = 3'd3;
  localparam logic [2:0] S_T3   = 3'd4;

  logic [2:0]    state;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;
  logic [1:0]    lanes_q;
  logic          rnw_q;
  logic          last_rd;
  logic          active;
  logic          io_sel;
  logic          gap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
      rnw_q   <= 1'b1;
      last_rd <= 1'b0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          lanes_q <= lanes;
          rnw_q   <= rnw;
          state   <= (!rnw && gap_en && last_rd) ? S_GAP : S_T1;
        end
        S_GAP: state <= S_T1;
        S_T1:  state <= S_T2;
        S_T2: begin
          if (rnw_q) state <= S_T3;
          else begin
            state   <= S_IDLE;
            done    <= 1'b1;
            last_rd <= 1'b0;
          end
        end
        S_T3: begin
          rdata   <= bus_din;
          done    <= 1'b1;
          last_rd <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign gap_now  = (state == S_GAP);
  assign active   = (state == S_T1) || (state == S_T2) || (state == S_T3);
  assign io_sel   = &addr_q[AW-1 -: IO_TAG_W];

  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;
  assign bus_oe   = active && !rnw_q;
  assign as_n     = !active;
  assign ios_n    = !(active && io_sel);
  assign cs_n     = !(active && !io_sel);
  assign rd_n     = !(active && rnw_q);
  assign hwr_n    = !(active && !rnw_q && lanes_q[1]);
  assign lwr_n    = !(active && !rnw_q && lanes_q[0]);
endmodule

module ext_bus_gap_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gap_now,
  input logic          last_rd,
  input logic [AW-1:0] bus_addr,
  input logic          bus_oe,
  input logic          as_n,
  input logic          ios_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          hwr_n,
  input logic          lwr_n,
  input logic          done
);
  p_gap_one_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |=> (!gap_now && !as_n && !bus_oe == 1'b0));
  p_gap_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |-> last_rd);
  p_gap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |-> (as_n && ios_n && cs_n && rd_n && hwr_n && lwr_n && !bus_oe));
  p_gap_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |=> $stable(bus_addr));
  p_no_drive_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);
  p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (hwr_n && lwr_n));
  p_select_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ios_n, ~cs_n}));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ext_bus_gap_ctrl ext_bus_gap_chk #(.AW(AW)) u_gap_chk (
  .clk(clk), .rst_n(rst_n), .gap_now(gap_now), .last_rd(last_rd),
  .bus_addr(bus_addr), .bus_oe(bus_oe), .as_n(as_n), .ios_n(ios_n),
  .cs_n(cs_n), .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n), .done(done)
);

// File: tb/test_ext_bus_gap_ctrl.sv
module test_ext_bus_gap_ctrl;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gap_en = 1'b0;
  logic          req = 1'b0;
  logic          rnw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [1:0]    lanes = '0;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_dout;
  logic          bus_oe;
  logic [15:0]   bus_din;
  logic          as_n, ios_n, cs_n, rd_n, hwr_n, lwr_n;
  logic [15:0]   rdata;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  bit last_rd_m = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dev_val(input logic [AW-1:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'hA5C3;
  endfunction

  function automatic bit is_io(input logic [AW-1:0] a);
    return a[AW-1 -: 8] == 8'hFF;
  endfunction

  assign bus_din = rd_n ? 16'hDEAD : dev_val(bus_addr);

  ext_bus_gap_ctrl #(.AW(AW)) i_ext_bus_gap_ctrl (
    .clk(clk), .rst_n(rst_n), .gap_en(gap_en), .req(req), .rnw(rnw),
    .addr(addr), .wdata(wdata), .lanes(lanes), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .as_n(as_n),
    .ios_n(ios_n), .cs_n(cs_n), .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n),
    .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] pins();
    return {as_n, ios_n, cs_n, rd_n, hwr_n, lwr_n, bus_oe};
  endfunction

  task automatic idle_check();
    chk(pins() == 7'b1111110, "R6/R9 idle pins quiet", pins(), 7'b1111110);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  task automatic txn(input bit r, input logic [AW-1:0] a, input logic [15:0] wd,
                     input logic [1:0] ln, input bit en);
    bit        exp_gap;
    int        exp_len;
    int        n;
    logic [6:0] ep;
    exp_gap = !r && en && last_rd_m;
    exp_len = r ? 4 : (exp_gap ? 4 : 3);
    rnw = r; addr = a; wdata = wd; lanes = ln; gap_en = en; req = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      n++;
      if (n == 1) begin
        if (exp_gap) begin
          chk(pins() == 7'b1111110, "R5 gap pins high, bus released", pins(), 7'b1111110);
          chk(bus_addr == a, "R5 gap address", bus_addr, a);
        end else if (r) begin
          ep = {1'b0, !is_io(a), is_io(a), 1'b0, 1'b1, 1'b1, 1'b0};
          chk(pins() == ep, "R1/R7 read T1 pins", pins(), ep);
        end
      end
      if (!r && n == (exp_gap ? 2 : 1)) begin
        ep = {1'b0, !is_io(a), is_io(a), 1'b1, !ln[1], !ln[0], 1'b1};
        chk(pins() == ep, "R2/R6/R7 write T1 pins", pins(), ep);
        chk(bus_dout == wd && bus_addr == a, "R2 write data and address", bus_dout, wd);
      end
      if (done || n > 8) break;
    end
    if (r)
      chk(n == exp_len, "R1/R4 read length", n, exp_len);
    else if (exp_gap)
      chk(n == exp_len, "R3 write length with gap", n, exp_len);
    else
      chk(n == exp_len, "R4 write length without gap", n, exp_len);
    if (r) chk(rdata == dev_val(a), "R1 read data", rdata, dev_val(a));
    last_rd_m = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int gaps;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins() == 7'b1111110 && done == 1'b0, "R9 reset state", {done, pins()}, 8'h7E);
    txn(1'b0, 24'h001000, 16'h1234, 2'b11, 1'b1);
    txn(1'b1, 24'hFF0040, 16'h0, 2'b00, 1'b1);
    txn(1'b0, 24'h002002, 16'hBEEF, 2'b10, 1'b1);
    txn(1'b0, 24'hFF0100, 16'h5A5A, 2'b01, 1'b1);
    txn(1'b1, 24'h0030A0, 16'h0, 2'b11, 1'b1);
    txn(1'b0, 24'h003100, 16'hC0DE, 2'b11, 1'b0);
    txn(1'b1, 24'h123456, 16'h0, 2'b11, 1'b1);
    txn(1'b1, 24'hFFFFFE, 16'h0, 2'b11, 1'b1);
    txn(1'b0, 24'h00ABCD, 16'h7777, 2'b11, 1'b1);
    @(negedge clk);
    idle_check();
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? {8'hFF, 16'($urandom)} : AW'($urandom);
      txn(1'($urandom), a, 16'($urandom), 2'($urandom), ($urandom % 4) != 0);
      gaps = $urandom % 3;
      for (int k = 0; k < gaps; k++) begin
        @(negedge clk);
        idle_check();
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule